// File: doc/BRIEF.md
# Scaled-Index Linear Address Generator

This block turns the addressing fields of a memory operand into a linear address. It adds an optional base register, an optional index register scaled by 1, 2, 4 or 8, and a displacement to form the effective offset. It then maps that offset through the current segment. In real mode the segment value is multiplied by sixteen and added to the low 16 bits of the offset. In protected mode the offset is added to the cached 32-bit descriptor base.

In protected mode the same cycle also checks the last byte of the access against the descriptor limit. The limit is scaled to bytes or to 4 KB pages according to the granularity bit. The result is registered, so every request presented with `req_valid` appears one clock later with `out_valid`. That result carries the linear address, the operand-size indication and the limit-violation flag. Loading descriptors and page translation belong to other blocks.

Top module: `agu_top`

## Requirements
- R1: The index term equals `index_val` shifted left by `scale_code` (code 0 gives ×1, 1 gives ×2, 2 gives ×4, 3 gives ×8).
- R2: The effective offset is the sum of the base term, the scaled index term and `disp`, taken modulo 2^32. The base term is `base_val` when `base_en` is 1 and zero otherwise. The index term is the scaled index when `index_en` is 1 and zero otherwise.
- R3: With `prot_mode` = 0, `lin_addr` equals `seg_val` × 16 plus the low 16 bits of the effective offset.
- R4: With `prot_mode` = 0, `limit_fault` is 0 whatever the descriptor fields hold, because no access checking applies in real mode.
- R5: With `prot_mode` = 1, `lin_addr` equals `desc_base` plus the effective offset, modulo 2^32.
- R6: The effective limit is `desc_limit` in bytes when `desc_gran` = 0. When `desc_gran` = 1 it is `desc_limit` shifted left by 12 with the low 12 bits set to one.
- R7: With `prot_mode` = 1, `limit_fault` is 1 exactly when offset + size − 1 exceeds the effective limit. This sum is computed in 33 bits. The size in bytes comes from `acc_size`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8.
- R8: `op32` is 1 only when `prot_mode` = 1 and `desc_big` = 1. Otherwise it is 0, meaning 16-bit operands.
- R9: `out_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 otherwise. When no request is taken, `lin_addr`, `op32` and `limit_fault` keep their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| base_val | input | 32 | Base register value |
| base_en | input | 1 | Base term is used |
| index_val | input | 32 | Index register value |
| index_en | input | 1 | Index term is used |
| scale_code | input | 2 | Index scale, power of two |
| disp | input | 32 | Displacement |
| prot_mode | input | 1 | 1 selects protected mode, 0 selects real mode |
| seg_val | input | 16 | Segment register value (real mode) |
| desc_base | input | 32 | Cached descriptor base |
| desc_limit | input | 20 | Cached descriptor limit |
| desc_gran | input | 1 | Limit counts 4 KB pages when 1 |
| desc_big | input | 1 | Default operand size is 32 bits when 1 |
| acc_size | input | 2 | Access size code |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| lin_addr | output | 32 | Linear address |
| op32 | output | 1 | 32-bit operand size indication |
| limit_fault | output | 1 | Limit violation |

## Verification
Address formation and the limit check act on the same request in the same cycle. A faulting request must still deliver its correctly computed linear address, and a non-faulting request must carry a clean flag. The bench provokes this in two ways. Directed requests put the last byte exactly on, and one byte past, a granularity-scaled limit while nonzero base and scaled index terms feed the address. Random requests mix both modes and all sizes. A reference model in the bench computes the address, size indication and flag for each request and compares all of them together on every clock.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // access size codes: bytes = 1 << code
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    localparam int SCALE_OPTS = 4;

    // bytes in the access minus one
    function automatic logic [3:0] span_minus1(input logic [1:0] code);
        logic [3:0] one_hot;
        one_hot = 4'b0001 << code;
        return one_hot - 4'd1;
    endfunction

endpackage

// File: rtl/agu_ea.sv
module agu_ea #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_val,
    input  logic          base_en,
    input  logic [AW-1:0] index_val,
    input  logic          index_en,
    input  logic [1:0]    scale_code,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] ea
);
    import agu_pkg::*;

    logic [AW-1:0] scaled_opts [SCALE_OPTS];
    logic [AW-1:0] base_term_d;
    logic [AW-1:0] index_term_d;

    // one shifted copy of the index per legal scale
    for (genvar g = 0; g < SCALE_OPTS; g++) begin : g_scale
        assign scaled_opts[g] = index_val << g;
    end

    always_comb begin
        base_term_d  = base_en  ? base_val : '0;
        index_term_d = index_en ? scaled_opts[scale_code] : '0;
        ea           = base_term_d + index_term_d + disp;
    end

endmodule

// File: rtl/agu_seg.sv
module agu_seg #(
    parameter int AW     = 32,
    parameter int SW     = 16,
    parameter int RW     = 16,
    parameter int SEG_SH = 4
) (
    input  logic [AW-1:0] ea,
    input  logic          prot_mode,
    input  logic [SW-1:0] seg_val,
    input  logic [AW-1:0] desc_base,
    output logic [AW-1:0] lin
);
    localparam int SEGX = SW + SEG_SH;

    logic [AW-1:0] seg_ext_d;
    logic [AW-1:0] off_real_d;
    logic [AW-1:0] lin_real_d;
    logic [AW-1:0] lin_prot_d;

    always_comb begin
        seg_ext_d  = {{(AW-SEGX){1'b0}}, seg_val, {SEG_SH{1'b0}}};
        off_real_d = {{(AW-RW){1'b0}}, ea[RW-1:0]};
        lin_real_d = seg_ext_d + off_real_d;
        lin_prot_d = desc_base + ea;
        lin        = prot_mode ? lin_prot_d : lin_real_d;
    end

endmodule

// File: rtl/agu_limit.sv
module agu_limit #(
    parameter int AW  = 32,
    parameter int LW  = 20,
    parameter int PSH = 12
) (
    input  logic [AW-1:0] ea,
    input  logic [1:0]    acc_size,
    input  logic          gran,
    input  logic [LW-1:0] limit,
    output logic          fault
);
    import agu_pkg::*;

    localparam int ELW = LW + PSH;

    logic [ELW-1:0] eff_lim_d;
    logic [AW:0]    last_byte_d;
    logic [AW:0]    span_d;
    logic [AW:0]    eff_ext_d;

    always_comb begin
        eff_lim_d   = gran ? {limit, {PSH{1'b1}}} : {{PSH{1'b0}}, limit};
        span_d      = '0;
        span_d[3:0] = span_minus1(acc_size);
        last_byte_d = {1'b0, ea} + span_d;
        eff_ext_d   = {{(AW+1-ELW){1'b0}}, eff_lim_d};
        fault       = last_byte_d > eff_ext_d;
    end

endmodule

// File: rtl/agu_top.sv
module agu_top #(
    parameter int AW     = 32,
    parameter int SW     = 16,
    parameter int RW     = 16,
    parameter int LW     = 20,
    parameter int PSH    = 12,
    parameter int SEG_SH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] base_val,
    input  logic          base_en,
    input  logic [AW-1:0] index_val,
    input  logic          index_en,
    input  logic [1:0]    scale_code,
    input  logic [AW-1:0] disp,
    input  logic          prot_mode,
    input  logic [SW-1:0] seg_val,
    input  logic [AW-1:0] desc_base,
    input  logic [LW-1:0] desc_limit,
    input  logic          desc_gran,
    input  logic          desc_big,
    input  logic [1:0]    acc_size,
    output logic          out_valid,
    output logic [AW-1:0] lin_addr,
    output logic          op32,
    output logic          limit_fault
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] lin;
        logic          op32;
        logic          flt;
    } agu_out_t;

    agu_out_t      out_d, out_q;
    logic [AW-1:0] ea_w;
    logic [AW-1:0] lin_w;
    logic          flt_w;

    agu_ea #(.AW(AW)) u_ea (
        .base_val  (base_val),
        .base_en   (base_en),
        .index_val (index_val),
        .index_en  (index_en),
        .scale_code(scale_code),
        .disp      (disp),
        .ea        (ea_w)
    );

    agu_seg #(.AW(AW), .SW(SW), .RW(RW), .SEG_SH(SEG_SH)) u_seg (
        .ea        (ea_w),
        .prot_mode (prot_mode),
        .seg_val   (seg_val),
        .desc_base (desc_base),
        .lin       (lin_w)
    );

    agu_limit #(.AW(AW), .LW(LW), .PSH(PSH)) u_lim (
        .ea        (ea_w),
        .acc_size  (acc_size),
        .gran      (desc_gran),
        .limit     (desc_limit),
        .fault     (flt_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = req_valid;
        if (req_valid) begin
            out_d.lin  = lin_w;
            out_d.op32 = prot_mode & desc_big;
            out_d.flt  = prot_mode & flt_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid   = out_q.vld;
    assign lin_addr    = out_q.lin;
    assign op32        = out_q.op32;
    assign limit_fault = out_q.flt;

    // R4
    real_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> !limit_fault);

    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(lin_addr) && $stable(limit_fault)));

    // R8
    size_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && desc_big) |=> op32);

    // R8
    size_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> !op32);

    // R7
    zero_off_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !base_en && !index_en && disp == '0 && acc_size == 2'd0)
        |=> !limit_fault);

endmodule

// File: tb/agu_top_tb.sv
module agu_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic        base_en = 1'b0;
    logic [31:0] index_val = '0;
    logic        index_en = 1'b0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp = '0;
    logic        prot_mode = 1'b0;
    logic [15:0] seg_val = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic        desc_big = 1'b0;
    logic [1:0]  acc_size = '0;
    logic        out_valid;
    logic [31:0] lin_addr;
    logic        op32;
    logic        limit_fault;

    always #4 clk = ~clk;

    agu_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .base_val(base_val), .base_en(base_en),
        .index_val(index_val), .index_en(index_en),
        .scale_code(scale_code), .disp(disp), .prot_mode(prot_mode),
        .seg_val(seg_val), .desc_base(desc_base), .desc_limit(desc_limit),
        .desc_gran(desc_gran), .desc_big(desc_big), .acc_size(acc_size),
        .out_valid(out_valid), .lin_addr(lin_addr), .op32(op32),
        .limit_fault(limit_fault)
    );

    typedef struct {
        bit        vld;
        bit [31:0] lin;
        bit        op32;
        bit        flt;
        string     tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 0;
    bit [31:0] held_lin = 0;
    bit        held_op32 = 0;
    bit        held_flt = 0;

    task automatic check_bit(input string what, input string tag,
                             input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic compare_front();
        exp_t e;
        e = exp_q.pop_front();
        check_bit("out_valid", {e.tag, " R9"}, out_valid, e.vld);
        check_bit("lin_addr", e.tag, lin_addr, e.lin);
        check_bit("op32", {e.tag, " R8"}, op32, e.op32);
        check_bit("limit_fault", e.tag, limit_fault, e.flt);
    endtask

    // reference model for one request
    task automatic send(input bit [31:0] b, input bit be, input bit [31:0] ix,
                        input bit ie, input bit [1:0] sc, input bit [31:0] d,
                        input bit pm, input bit [15:0] sg, input bit [31:0] db,
                        input bit [19:0] lm, input bit g, input bit big,
                        input bit [1:0] sz, input string tag);
        longint ea, lin, eff, last;
        exp_t   e;
        @(negedge clk);
        compare_front();
        req_valid = 1; base_val = b; base_en = be; index_val = ix; index_en = ie;
        scale_code = sc; disp = d; prot_mode = pm; seg_val = sg; desc_base = db;
        desc_limit = lm; desc_gran = g; desc_big = big; acc_size = sz;
        ea = 0;
        if (be) ea += b;
        if (ie) ea += longint'(ix) * (longint'(1) << sc);
        ea = (ea + d) % 64'h1_0000_0000;
        if (pm) lin = (db + ea) % 64'h1_0000_0000;
        else    lin = longint'(sg) * 16 + (ea % 65536);
        eff  = g ? (longint'(lm) * 4096 + 4095) : longint'(lm);
        last = ea + (longint'(1) << sz) - 1;
        e.vld = 1; e.lin = lin[31:0]; e.op32 = pm && big;
        e.flt = pm && (last > eff);
        e.tag = pm ? {tag, " R5 R7"} : {tag, " R3 R4"};
        held_lin = e.lin; held_op32 = e.op32; held_flt = e.flt;
        exp_q.push_back(e);
    endtask

    task automatic idle(input bit scramble);
        exp_t e;
        @(negedge clk);
        compare_front();
        req_valid = 0;
        if (scramble) begin
            base_val = $urandom; disp = $urandom; prot_mode = $urandom;
            desc_limit = '0; acc_size = 2'd3; base_en = 1;
        end
        e.vld = 0; e.lin = held_lin; e.op32 = held_op32; e.flt = held_flt;
        e.tag = "R9 hold";
        exp_q.push_back(e);
    endtask

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        r.vld = 0; r.lin = 0; r.op32 = 0; r.flt = 0; r.tag = "R9 reset";
        exp_q.push_back(r);

        // R1 each scale code, index only plus displacement
        for (int s = 0; s < 4; s++)
            send(0, 0, 32'h0000_1234, 1, s[1:0], 32'h10, 1, 0, 32'h0010_0000,
                 20'hFFFFF, 1, 1, 0, "R1 scale");
        // R2 base plus scaled index, then all three, then terms disabled
        send(32'h0000_4000, 1, 32'h8, 1, 2'd3, 0, 1, 0, 0, 20'hFFFFF, 1, 0, 2, "R2 b+i");
        send(32'h0000_4000, 1, 32'h8, 1, 2'd2, 32'hFFFF_FFF0, 1, 0, 0, 20'hFFFFF, 1, 1, 2, "R2 b+i+d");
        send(32'hDEAD_BEEF, 0, 32'hCAFE, 0, 2'd1, 32'h77, 1, 0, 32'h100, 20'hFFFFF, 1, 1, 0, "R2 disabled");
        send(32'hFFFF_FFFF, 1, 32'h8000_0000, 1, 2'd1, 32'h2, 1, 0, 0, 20'hFFFFF, 1, 1, 0, "R2 wrap");
        // R3/R4 real mode, offset truncated, junk descriptor
        send(32'h0001_FFFE, 1, 32'h3, 1, 2'd0, 0, 0, 16'hF000, 32'h1234, 20'h0, 0, 1, 3, "R3 trunc");
        send(0, 0, 0, 0, 2'd0, 32'hFFFF, 0, 16'hFFFF, 0, 20'h0, 0, 0, 3, "R4 top");
        // R6/R7 byte granularity boundary
        send(32'h100, 1, 0, 0, 2'd0, 0, 1, 0, 32'h5000, 20'h100, 0, 0, 0, "R6 R7 byte-at");
        send(32'h100, 1, 0, 0, 2'd0, 0, 1, 0, 32'h5000, 20'h100, 0, 0, 1, "R6 R7 byte-past");
        idle(1);
        idle(0);
        // R6/R7 page granularity boundary with base and scaled index
        send(32'h3F00, 1, 32'h3F, 1, 2'd2, 0, 1, 0, 32'h9000_0000, 20'h3, 1, 1, 2, "R6 R7 page-at");
        send(32'h3F00, 1, 32'h3F, 1, 2'd2, 32'h1, 1, 0, 32'h9000_0000, 20'h3, 1, 1, 2, "R6 R7 page-past");
        send(32'h4000, 1, 0, 0, 2'd0, 0, 1, 0, 0, 20'h3, 0, 0, 0, "R6 gran-off");
        // R7 33-bit last byte beyond 4 GB
        send(32'hFFFF_FFFC, 1, 0, 0, 2'd0, 0, 1, 0, 0, 20'hFFFFF, 1, 1, 3, "R7 top-wrap");

        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 4) == 0) idle($urandom_range(0, 1));
            else send($urandom, $urandom_range(0, 1), $urandom, $urandom_range(0, 1),
                      $urandom_range(0, 3), $urandom, $urandom_range(0, 1), $urandom,
                      $urandom, $urandom, $urandom_range(0, 1), $urandom_range(0, 1),
                      $urandom_range(0, 3), "R1 R2 R6 R8 random");
        end
        idle(0);
        idle(0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog expired: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule